// File: doc/BRIEF.md
# Event Performance Counter Unit

This unit counts hardware events for a single processor core. It has four programmable 32-bit event counters and one 32-bit cycle counter. Each event counter picks one event number and watches a 128-wide vector of single-cycle event pulses. Each cycle in which the chosen pulse is high, the counter advances by one. The cycle counter advances on each clock. It can instead advance once every 64 clocks, and it can pause while the core is halted for debug.

Software drives the unit over a plain register bus. That bus has a word address, a write strobe, write data and combinational read data. Count enables and interrupt enables each have their own set register and clear register. The event counters are reached indirectly: a select register names one of them, and the event-type and event-count registers then reach that counter. The cycle counter has its own value register.

A counter that wraps from all ones to zero sets a sticky overflow flag. To sample every N events, software preloads a counter with the two's complement of N. The interrupt line stays high while any flag whose interrupt is enabled is set.

Top module: `perf_mon`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq_o` is low.
- R2: The control register is at address 0. Bit 0 is the global run enable. Bit 3 selects slow cycle counting. Bit 4 is a stored export flag. Bit 5 is the debug-halt gate. Each of these bits reads back as written. Bits 1 and 2 and bits 31:6 always read 0.
- R3: The count-enable set register is at address 1 and the clear register is at address 2. In both, bits 3:0 stand for event counters 0 to 3 and bit 31 stands for the cycle counter. A 1 in the set register enables that counter. A 1 in the clear register disables it. A 0 bit changes nothing. Both addresses read the current enables, and all other bits read 0.
- R4: The interrupt-enable set register is at address 3 and the clear register is at address 4. They use the same bit layout and the same set, clear and read-back rules as R3.
- R5: An event counter advances by one in a cycle only if all three of these are true in that cycle: the run bit is set, its count-enable bit is set, and `events_i[n]` is high, where n is its event number. The counter is read and written at address 8, through the select register.
- R6: The select register is at address 6 and keeps bits 4:0 of the written data. When it holds 4 or more, addresses 7 and 8 read zero and writes to them change no counter.
- R7: The event-type register is at address 7 and stores bits 6:0 of the written data for the selected counter. Higher bits are dropped.
- R8: A counter that advances from 32'hFFFFFFFF to 0 sets its bit in the overflow register at address 5. The bit layout is the same as in R3. The flag stays set until a 1 is written to that bit. If a wrap and a clear of the same flag happen in the same cycle, the flag stays set.
- R9: The cycle counter is at address 9 and can be written directly. When the run bit and count-enable bit 31 are both set, it advances once per clock.
- R10: With control bit 3 set, the cycle counter advances only once in every 64 enabled clocks. The first advance comes on the 64th enabled clock.
- R11: With control bit 5 set, the cycle counter and its prescaler hold while `debug_halt_i` is high. With bit 5 clear, `debug_halt_i` has no effect.
- R12: A control write with bit 1 set zeroes all event counters on the next cycle. A control write with bit 2 set zeroes the cycle counter and its prescaler on the next cycle. Neither reset sets an overflow flag.
- R13: `irq_o` is high exactly when some overflow flag is set and its interrupt-enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| events_i | input | 128 | Event pulse vector, indexed by event number |
| debug_halt_i | input | 1 | Core debug-halt status |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
The event counters are first driven with single isolated pulses on chosen event numbers, which checks that each counter decodes only its own number. Dense and sparse random pulse vectors then check that counters with different event types advance independently. Runs with the run bit or an enable cleared check the three-way gating condition. Directed preloads near all ones are used for the wrap and the flag, for a wrap that coincides with a clear, and for the interrupt. Separate runs with slow mode on, and with debug-halt toggled under both gate settings, check the prescaler phase and the halt gate.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 32;
    localparam int EVT_W   = 7;
    localparam int SEL_W   = 5;
    localparam int PRESC_W = 6;
    localparam int CYC_BIT = 31;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 4'd0,
        A_CEN_SET = 4'd1,
        A_CEN_CLR = 4'd2,
        A_IEN_SET = 4'd3,
        A_IEN_CLR = 4'd4,
        A_OVF     = 4'd5,
        A_SEL     = 4'd6,
        A_EVTYPE  = 4'd7,
        A_EVCNT   = 4'd8,
        A_CYC     = 4'd9
    } addr_e;

    typedef struct packed {
        logic halt_gate;
        logic export_en;
        logic slow_cyc;
        logic run;
    } ctrl_t;

    // Bits of a per-counter word that exist: low event bits plus the cycle bit.
    function automatic word_t ctr_mask(input int n_evt);
        word_t m;
        m = '0;
        for (int i = 0; i < n_evt; i++) m[i] = 1'b1;
        m[CYC_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pmu_ctr.sv
module pmu_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         wrap
);
    always_ff @(posedge clk) begin
        if (rst || clr)  val <= '0;
        else if (wr)     val <= wdata;
        else if (inc)    val <= val + 1'b1;
    end

    assign wrap = inc && !clr && !wr && (&val);
endmodule

// File: rtl/pmu_cyc_gate.sv
module pmu_cyc_gate #(
    parameter int PW = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic en,
    input  logic slow,
    input  logic halt_gate,
    input  logic halt_i,
    output logic tick
);
    logic [PW-1:0] presc_q;
    logic          open_w;

    assign open_w = run && en && !(halt_gate && halt_i);

    always_ff @(posedge clk) begin
        if (rst || clr)            presc_q <= '0;
        else if (open_w && slow)   presc_q <= presc_q + 1'b1;
    end

    assign tick = open_w && (!slow || (&presc_q));
endmodule

// File: rtl/pmu_regs.sv
module pmu_regs
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              we,
    input  word_t                             wdata,
    input  logic [NUM_CTR-1:0][CNT_W-1:0]     evt_vals,
    input  logic [CNT_W-1:0]                  cyc_val,
    input  logic [NUM_CTR-1:0]                ovf_evt,
    input  logic                              ovf_cyc,
    output word_t                             rdata,
    output logic                              irq,
    output logic                              run,
    output logic                              slow,
    output logic                              halt_gate,
    output logic [NUM_CTR-1:0]                evt_en,
    output logic                              cyc_en,
    output logic [NUM_CTR-1:0][EVT_W-1:0]     evtype,
    output logic [NUM_CTR-1:0]                evt_wr,
    output logic                              cyc_wr,
    output logic                              evt_clr,
    output logic                              cyc_clr
);
    localparam word_t MASK = ctr_mask(NUM_CTR);

    addr_e                        a;
    ctrl_t                        ctrl_q;
    word_t                        cen_q, ien_q, ovf_q;
    logic [SEL_W-1:0]             sel_q;
    logic [NUM_CTR-1:0][EVT_W-1:0] evtype_q;
    word_t                        ovf_set, ovf_clr, wmask;

    assign a     = addr_e'(addr);
    assign wmask = wdata & MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cen_q    <= '0;
            ien_q    <= '0;
            sel_q    <= '0;
            evtype_q <= '0;
        end else if (we) begin
            case (a)
                A_CTRL: begin
                    ctrl_q.run       <= wdata[0];
                    ctrl_q.slow_cyc  <= wdata[3];
                    ctrl_q.export_en <= wdata[4];
                    ctrl_q.halt_gate <= wdata[5];
                end
                A_CEN_SET: cen_q <= cen_q | wmask;
                A_CEN_CLR: cen_q <= cen_q & ~wmask;
                A_IEN_SET: ien_q <= ien_q | wmask;
                A_IEN_CLR: ien_q <= ien_q & ~wmask;
                A_SEL:     sel_q <= wdata[SEL_W-1:0];
                A_EVTYPE: begin
                    for (int i = 0; i < NUM_CTR; i++)
                        if (sel_q == SEL_W'(i)) evtype_q[i] <= wdata[EVT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ovf_set                = '0;
        ovf_set[NUM_CTR-1:0]   = ovf_evt;
        ovf_set[CYC_BIT]       = ovf_cyc;
        ovf_clr                = (we && a == A_OVF) ? wmask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= '0;
        else     ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
    end

    // Strobes to the counters.
    always_comb begin
        for (int i = 0; i < NUM_CTR; i++)
            evt_wr[i] = we && (a == A_EVCNT) && (sel_q == SEL_W'(i));
    end
    assign cyc_wr  = we && (a == A_CYC);
    assign evt_clr = we && (a == A_CTRL) && wdata[1];
    assign cyc_clr = we && (a == A_CTRL) && wdata[2];

    assign run       = ctrl_q.run;
    assign slow      = ctrl_q.slow_cyc;
    assign halt_gate = ctrl_q.halt_gate;
    assign evt_en    = cen_q[NUM_CTR-1:0];
    assign cyc_en    = cen_q[CYC_BIT];
    assign evtype    = evtype_q;
    assign irq       = |(ovf_q & ien_q);

    always_comb begin
        rdata = '0;
        case (a)
            A_CTRL:    rdata = {26'b0, ctrl_q.halt_gate, ctrl_q.export_en,
                                ctrl_q.slow_cyc, 2'b00, ctrl_q.run};
            A_CEN_SET,
            A_CEN_CLR: rdata = cen_q;
            A_IEN_SET,
            A_IEN_CLR: rdata = ien_q;
            A_OVF:     rdata = ovf_q;
            A_SEL:     rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q};
            A_EVTYPE: begin
                for (int i = 0; i < NUM_CTR; i++)
                    if (sel_q == SEL_W'(i))
                        rdata = {{(DATA_W-EVT_W){1'b0}}, evtype_q[i]};
            end
            A_EVCNT: begin
                for (int i = 0; i < NUM_CTR; i++)
                    if (sel_q == SEL_W'(i)) rdata = evt_vals[i];
            end
            A_CYC:     rdata = cyc_val;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/perf_mon.sv
module perf_mon
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 2 ** EVT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] events_i,
    input  logic               debug_halt_i,
    output logic               irq_o
);
    logic [NUM_CTR-1:0][CNT_W-1:0] evt_vals;
    logic [CNT_W-1:0]              cyc_val;
    logic [NUM_CTR-1:0]            ovf_evt, evt_en, evt_wr, evt_inc;
    logic                          ovf_cyc, cyc_en, cyc_wr, cyc_tick;
    logic                          run, slow, halt_gate, evt_clr, cyc_clr;
    logic [NUM_CTR-1:0][EVT_W-1:0] evtype;

    pmu_regs #(.NUM_CTR(NUM_CTR)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .evt_vals(evt_vals), .cyc_val(cyc_val), .ovf_evt(ovf_evt), .ovf_cyc(ovf_cyc),
        .rdata(bus_rdata), .irq(irq_o), .run(run), .slow(slow), .halt_gate(halt_gate),
        .evt_en(evt_en), .cyc_en(cyc_en), .evtype(evtype), .evt_wr(evt_wr),
        .cyc_wr(cyc_wr), .evt_clr(evt_clr), .cyc_clr(cyc_clr)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_evt
        assign evt_inc[i] = run && evt_en[i] && events_i[evtype[i]];

        pmu_ctr #(.W(CNT_W)) u_ctr (
            .clk(clk), .rst(rst), .clr(evt_clr), .wr(evt_wr[i]),
            .wdata(bus_wdata[CNT_W-1:0]), .inc(evt_inc[i]),
            .val(evt_vals[i]), .wrap(ovf_evt[i])
        );
    end

    pmu_cyc_gate #(.PW(PRESC_W)) u_gate (
        .clk(clk), .rst(rst), .clr(cyc_clr), .run(run), .en(cyc_en),
        .slow(slow), .halt_gate(halt_gate), .halt_i(debug_halt_i), .tick(cyc_tick)
    );

    pmu_ctr #(.W(CNT_W)) u_cyc (
        .clk(clk), .rst(rst), .clr(cyc_clr), .wr(cyc_wr),
        .wdata(bus_wdata[CNT_W-1:0]), .inc(cyc_tick),
        .val(cyc_val), .wrap(ovf_cyc)
    );
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic [SEL_W-1:0]  sel_q,
    input logic [DATA_W-1:0] ovf_q,
    input logic [DATA_W-1:0] cen_q,
    input logic [CNT_W-1:0]  cyc_val
);
    localparam logic [DATA_W-1:0] MASK = ctr_mask(NUM_CTR);

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_CTRL) |-> (bus_rdata[31:6] == '0 && bus_rdata[2:1] == 2'b00));

    // R3
    enable_layout_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= A_CEN_SET && bus_addr <= A_OVF) |-> ((bus_rdata & ~MASK) == '0));

    // R3
    enable_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CEN_SET)
        |=> ((cen_q & $past(bus_wdata) & MASK) == ($past(bus_wdata) & MASK)));

    // R6
    sel_range_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr == A_EVTYPE || bus_addr == A_EVCNT) && (32'(sel_q) >= NUM_CTR))
        |-> (bus_rdata == '0));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == A_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    // R12
    cyc_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CTRL && bus_wdata[2]) |=> (cyc_val == '0));

    // R13
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_IEN_CLR && bus_wdata == '1) |=> !irq_o);
endmodule

bind perf_mon pmu_chk #(.NUM_CTR(NUM_CTR)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .sel_q(u_regs.sel_q), .ovf_q(u_regs.ovf_q), .cen_q(u_regs.cen_q),
    .cyc_val(cyc_val)
);

// File: tb/perf_mon_bench.sv
module perf_mon_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   b_addr = '0;
    logic         b_we = 1'b0;
    logic [31:0]  b_wdata = '0;
    logic [127:0] b_ev = '0;
    logic         b_halt = 1'b0;
    logic [31:0]  rdata;
    logic         irq;

    logic [127:0] ev_next = '0;
    logic         halt_next = 1'b0;
    logic         rst_next = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5ns clk = ~clk;

    perf_mon u_perf_mon (
        .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_we(b_we), .bus_wdata(b_wdata),
        .bus_rdata(rdata), .events_i(b_ev), .debug_halt_i(b_halt), .irq_o(irq)
    );

    // Behavioural reference state.
    localparam logic [31:0] M = 32'h8000_000F;
    logic [31:0] m_cnt [4];
    logic [6:0]  m_evt [4];
    logic [31:0] m_cyc, m_cen, m_ien, m_ovf;
    logic [4:0]  m_sel;
    bit          m_run, m_x, m_d, m_dp;
    int          m_presc;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_evt[i] = 0; end
            m_cyc = 0; m_cen = 0; m_ien = 0; m_ovf = 0; m_sel = 0;
            m_run = 0; m_x = 0; m_d = 0; m_dp = 0; m_presc = 0;
        end else begin
            logic [31:0] setf;
            bit gate, tick, rs_e, rs_c;
            setf = 0;
            rs_e = b_we && b_addr == 0 && b_wdata[1];
            rs_c = b_we && b_addr == 0 && b_wdata[2];
            for (int i = 0; i < 4; i++) begin
                if (rs_e) m_cnt[i] = 0;
                else if (b_we && b_addr == 8 && m_sel == i) m_cnt[i] = b_wdata;
                else if (m_run && m_cen[i] && b_ev[m_evt[i]]) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) setf[i] = 1;
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
            gate = m_run && m_cen[31] && !(m_dp && b_halt);
            tick = gate && (!m_d || m_presc == 63);
            if (rs_c) begin
                m_cyc = 0; m_presc = 0;
            end else begin
                if (gate && m_d) m_presc = (m_presc + 1) % 64;
                if (b_we && b_addr == 9) m_cyc = b_wdata;
                else if (tick) begin
                    if (m_cyc == 32'hFFFF_FFFF) setf[31] = 1;
                    m_cyc = m_cyc + 1;
                end
            end
            if (b_we && b_addr == 5) m_ovf = m_ovf & ~(b_wdata & M);
            m_ovf = m_ovf | setf;
            if (b_we) begin
                case (b_addr)
                    0: begin m_run = b_wdata[0]; m_d = b_wdata[3]; m_x = b_wdata[4]; m_dp = b_wdata[5]; end
                    1: m_cen = m_cen | (b_wdata & M);
                    2: m_cen = m_cen & ~(b_wdata & M);
                    3: m_ien = m_ien | (b_wdata & M);
                    4: m_ien = m_ien & ~(b_wdata & M);
                    6: m_sel = b_wdata[4:0];
                    7: if (m_sel < 4) m_evt[m_sel[1:0]] = b_wdata[6:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            0: return {26'b0, m_dp, m_x, m_d, 2'b00, m_run};
            1, 2: return m_cen;
            3, 4: return m_ien;
            5: return m_ovf;
            6: return {27'b0, m_sel};
            7: return (m_sel < 4) ? {25'b0, m_evt[m_sel[1:0]]} : 32'h0;
            8: return (m_sel < 4) ? m_cnt[m_sel[1:0]] : 32'h0;
            9: return m_cyc;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            0: return "R2";
            1, 2: return "R3";
            3, 4: return "R4";
            5: return "R8";
            6: return "R6";
            7: return "R7";
            8: return "R5";
            9: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic compare_now();
        logic [31:0] er;
        logic ei;
        er = model_read(b_addr);
        ei = |(m_ovf & m_ien);
        checks++;
        if (rdata !== er) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag_of(b_addr), b_addr, rdata, er);
        end
        checks++;
        if (irq !== ei) begin
            fails++;
            $display("FAIL R13 irq actual=%b expected=%b", irq, ei);
        end
    endtask

    task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        compare_now();
        rst = rst_next; b_addr = a; b_we = w; b_wdata = d;
        b_ev = ev_next; b_halt = halt_next;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(a, 1'b1, d);
    endtask

    task automatic rd(input logic [3:0] a, input int n);
        for (int k = 0; k < n; k++) step(a, 1'b0, 32'h0);
    endtask

    function automatic logic [127:0] onehot(input int n);
        logic [127:0] v;
        v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    initial begin
        // R1: reset state on every address
        rd(0, 3);
        rst_next = 1'b0;
        for (int a = 0; a < 16; a++) rd(a[3:0], 1);

        // R2: control bits, self-clearing resets
        wr(0, 32'hFFFF_FFFF); rd(0, 2);
        wr(0, 32'h0); rd(0, 1);

        // R3 / R4: set and clear
        wr(1, 32'hFFFF_FFFF); rd(1, 1); rd(2, 1);
        wr(2, 32'h0000_0002); rd(1, 1);
        wr(2, 32'h0); rd(2, 1);
        wr(2, 32'hFFFF_FFFF); rd(1, 1);
        wr(3, 32'h8000_0005); rd(3, 1); rd(4, 1);
        wr(4, 32'h8000_0000); rd(3, 1);
        wr(4, 32'hFFFF_FFFF); rd(4, 1);

        // R6 / R7: select and event types
        wr(6, 32'hFFFF_FFE0); rd(6, 1);
        wr(7, 32'h0000_0FFF); rd(7, 1);
        wr(6, 1); wr(7, 32'h85); rd(7, 1);
        wr(6, 2); wr(7, 9);    rd(7, 1);
        wr(6, 3); wr(7, 0);    rd(7, 1);
        wr(6, 7); wr(7, 3); wr(8, 32'h1234); rd(7, 1); rd(8, 1);
        wr(6, 31); rd(8, 1);
        for (int s = 0; s < 4; s++) begin wr(6, s); rd(7, 1); rd(8, 1); end

        // R5: isolated pulses, run on, all event counters enabled
        wr(1, 32'hF); wr(0, 1);
        for (int e = 0; e < 128; e += 9) begin
            ev_next = onehot(e); rd(8, 1);
            ev_next = '0; rd(8, 1);
        end
        ev_next = onehot(127); rd(8, 2); ev_next = onehot(5); rd(8, 2);
        ev_next = onehot(9); rd(8, 2); ev_next = '0;
        // R5: dense and sparse random patterns, select rotating
        for (int k = 0; k < 200; k++) begin
            ev_next = {$urandom, $urandom, $urandom, $urandom};
            if (k >= 100) ev_next = ev_next & {$urandom, $urandom, $urandom, $urandom};
            if (k % 10 == 0) wr(6, (k / 10) % 4); else rd(8, 1);
        end
        // R5: gating by run bit and by own enable
        ev_next = '1;
        wr(0, 0); rd(8, 5);
        wr(0, 1); wr(2, 32'h2); wr(6, 1); rd(8, 5); wr(6, 0); rd(8, 3);
        wr(1, 32'h2); ev_next = '0;

        // R8: wrap on counter 1, sticky, W1C, coincident clear
        wr(6, 1); wr(8, 32'hFFFF_FFFE);
        ev_next = onehot(5); rd(8, 3); ev_next = '0; rd(5, 3);
        wr(5, 32'h0); rd(5, 1);
        wr(5, 32'h2); rd(5, 1);
        wr(8, 32'hFFFF_FFFF); rd(5, 1);
        ev_next = onehot(5); wr(5, 32'h2); ev_next = '0; rd(5, 2);

        // R13: interrupt follows flag and enable
        wr(3, 32'h1); rd(5, 1);
        wr(3, 32'h2); rd(5, 2);
        wr(5, 32'h2); rd(5, 1);
        wr(5, 32'h0); wr(4, 32'hFFFF_FFFF); rd(5, 1);

        // R9: cycle counter direct write and wrap
        wr(1, 32'h8000_0000); wr(9, 32'hFFFF_FFF0); rd(9, 20); rd(5, 1);
        wr(3, 32'h8000_0000); rd(9, 2); wr(5, 32'h8000_0000); rd(9, 2);

        // R12: resets zero counters without setting flags
        wr(6, 2); wr(8, 32'hFFFF_FFFF); ev_next = onehot(9);
        wr(0, 32'h7); ev_next = '0; rd(8, 2); rd(9, 2); rd(5, 1);
        wr(0, 32'h3); rd(8, 1); wr(0, 32'h5); rd(9, 2);

        // R10: divide by 64
        wr(0, 32'h4); wr(0, 32'h9); rd(9, 200);
        wr(0, 32'h1); rd(9, 5);

        // R11: halt gate
        wr(0, 32'h29); halt_next = 1'b1; rd(9, 70); halt_next = 1'b0; rd(9, 70);
        wr(0, 32'h21); halt_next = 1'b1; rd(9, 10); halt_next = 1'b0; rd(9, 5);
        wr(0, 32'h01); halt_next = 1'b1; rd(9, 10); halt_next = 1'b0;
        rd(0, 2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule